// File: doc/BRIEF.md
# SD Host Command Issuer

This block sits between a host controller's register file and the card-side command engine. A write to the command register is masked, decoded into its index, response type, data-present flag and direction, and handed to a card-facing request/response handshake. When the card side answers, the response bytes are laid big-endian into four 32-bit response words. The block then raises a one-cycle event for command complete, command timeout, card error or transfer complete. It also keeps the present-state flags that tell software a command or a data transfer is in flight.

The block checks the byte count it gets back against the response type that was requested, and it screens card status bits per command class against a software-supplied error-enable mask. Stop commands (index 12 or 52) end any data transfer. If such a stop is written while data is still moving, it is parked and launched automatically once the data path reports the transfer finished. Serial framing, CRC generation and the data buffer live elsewhere.

Control is a three-state machine. In IDLE it waits for a command write or a parked stop. The ISSUE transition goes to WAIT for a normal command, or straight to EVAL for the two local shortcuts (no card attached, init-mode index 0). In WAIT it holds the request until the card answers (RESPOND transition) or the cycle limit runs out (EXPIRE transition). In EVAL it spends one cycle grading the result and always returns to IDLE (RETIRE transition).

Top module: `sdc_cmd_issue`

## Requirements
- R1: After reset every event output, `req_valid`, `buf_reset`, `stop_held`, `pstate` and all four response words are zero.
- R2: `cmd_reg` holds the written word ANDed with 0x3FFB0037. Fields are index [29:24], data-present [21], response type [17:16] and direction [4] (1 = read). A command write that arrives while `pstate[0]` (command inhibit) is high is ignored.
- R3: A normal command drives `req_valid` high from the cycle after the write until the card answers or the limit expires. `req_index` and `req_arg` carry the index and the argument sampled at the write.
- R4: Response type 1 (136-bit) needs at least 16 bytes. Byte i sits at `rsp_bytes[127-8i -: 8]`. Bytes 0..3 form `resp_w3` and bytes 12..15 form `resp_w0`, each with the lower byte number in the high bits.
- R5: Response types 2 and 3 (48-bit, and 48-bit with busy) need at least 4 bytes and load bytes 0..3 into `resp_w0` only. Type 0 loads no word. A satisfied command pulses `ev_cc`.
- R6: If fewer bytes arrive than the type needs, or no answer arrives within `TIMEOUT_CYCLES` cycles of waiting, `ev_cto` pulses instead of `ev_cc` and no response word changes. Type 0 never times out.
- R7: Card-status checking applies only to 48-bit responses. For index 3, bytes 2..3 are checked against 0x0E00. Index 41 is never checked, and neither is index 8 when `card_is_mmc` is low. Every other index checks bytes 0..3 against 0xFDF98000. A bit set in the status, the mask and `err_en` pulses `ev_cerr` and clears the transfer flags.
- R8: With `init_mode` high, index 0 issues no request and pulses only `ev_cc`.
- R9: With `card_present` low, any command issues no request and pulses only `ev_cto`.
- R10: A type-3 command with no data phase, no timeout and no card error also pulses `ev_tc`.
- R11: A data-present command pulses `buf_reset` and sets `pstate[2:1]`. It also sets `pstate[9]` for a read or `pstate[8]` for a write, and latches `xfer_dir`. A `xfer_done` pulse clears these bits. A command without data clears them.
- R12: Issuing index 12 or 52 clears the transfer flags and pulses `buf_rdy_clr`, `dma_drop` and `ev_tc`.
- R13: Index 12 or 52 written while `pstate[2]` is high and no stop is already held is not issued. Instead `stop_held` rises. After the transfer ends, the held stop is issued with its saved argument.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write data |
| arg_in | input | 32 | Command argument, sampled at the write |
| err_en | input | 32 | Card status error-enable mask |
| init_mode | input | 1 | Initialization-mode control bit |
| card_present | input | 1 | A card is attached |
| card_is_mmc | input | 1 | Attached card is MMC rather than SD |
| xfer_done | input | 1 | Data path finished the transfer |
| req_valid | output | 1 | Command request to the card side |
| req_index | output | 6 | Requested command index |
| req_arg | output | 32 | Requested command argument |
| rsp_valid | input | 1 | Card side answers, one cycle |
| rsp_len | input | 5 | Number of response bytes returned |
| rsp_bytes | input | 128 | Response bytes, byte 0 in the top bits |
| cmd_reg | output | 32 | Masked command register |
| resp_w0 | output | 32 | Response word, bytes 12..15 or short response |
| resp_w1 | output | 32 | Response word, bytes 8..11 |
| resp_w2 | output | 32 | Response word, bytes 4..7 |
| resp_w3 | output | 32 | Response word, bytes 0..3 |
| pstate | output | 10 | Present state: 0 inhibit, 2..1 data, 8 write, 9 read |
| xfer_dir | output | 1 | Latched data direction (1 = read) |
| buf_reset | output | 1 | Pulse: reset the data buffer |
| buf_rdy_clr | output | 1 | Pulse: clear buffer-ready flags |
| dma_drop | output | 1 | Pulse: drop both DMA requests |
| ev_cc | output | 1 | Pulse: command complete |
| ev_cto | output | 1 | Pulse: command timeout |
| ev_cerr | output | 1 | Pulse: card error |
| ev_tc | output | 1 | Pulse: transfer complete |
| stop_held | output | 1 | A stop command is parked |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` set to 6, so the EXPIRE transition takes only a few cycles and every command finishes within a short fixed window. With that setting the bench can sweep every response type against byte counts on both sides of the 4- and 16-byte thresholds, with and without a data phase. It also sweeps the status-check classes across card kinds, status patterns and enable masks, and computes each expected event and response word directly from the requirements.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam logic [31:0] CMD_WMASK      = 32'h3FFB_0037;
    localparam logic [31:0] STATUS_ERRMASK = 32'hFDF9_8000;
    localparam logic [15:0] RCA_ERRMASK    = 16'h0E00;
    localparam logic [5:0]  IDX_STOP       = 6'd12;
    localparam logic [5:0]  IDX_IOABORT    = 6'd52;
    localparam logic [5:0]  IDX_RCA        = 6'd3;
    localparam logic [5:0]  IDX_OCR        = 6'd41;
    localparam logic [5:0]  IDX_IFCOND     = 6'd8;
    localparam int          RSP_WORDS      = 4;

    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_LONG  = 2'd1,
        RT_SHORT = 2'd2,
        RT_BUSY  = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EVAL = 2'd2
    } issue_st_e;

    typedef enum logic [1:0] {
        FL_NORMAL = 2'd0,
        FL_INIT0  = 2'd1,
        FL_NOCARD = 2'd2
    } flow_e;

    typedef struct packed {
        logic [5:0] idx;
        logic       data_present;
        rsp_kind_e  kind;
        logic       rd;
    } cmd_fields_t;
endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic [31:0] word,
    output cmd_fields_t fields,
    output logic        is_stop
);
    always_comb begin
        fields.idx          = word[29:24];
        fields.data_present = word[21];
        fields.kind         = rsp_kind_e'(word[17:16]);
        fields.rd           = word[4];
        is_stop             = (word[29:24] == IDX_STOP) || (word[29:24] == IDX_IOABORT);
    end
endmodule

// File: rtl/sdc_wait_timer.sv
module sdc_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!hit)
            cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/sdc_rsp_eval.sv
module sdc_rsp_eval
    import sdc_pkg::*;
(
    input  cmd_fields_t            fields,
    input  logic                   card_is_mmc,
    input  logic [4:0]             len,
    input  logic [127:0]           bytes_in,
    input  logic [31:0]            err_en,
    output logic                   timeout,
    output logic                   load_all,
    output logic                   load_low,
    output logic                   status_hit,
    output logic [RSP_WORDS-1:0][31:0] words
);
    logic [31:0] chk_mask;
    logic [31:0] chk_word;
    logic        is_short;

    // word k takes bytes 4*(3-k) .. 4*(3-k)+3, lower byte number in high bits
    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
        assign words[k] = bytes_in[32*k +: 32];
    end

    always_comb begin
        is_short = (fields.kind == RT_SHORT) || (fields.kind == RT_BUSY);
        timeout  = ((fields.kind == RT_LONG) && (len < 5'd16)) ||
                   (is_short && (len < 5'd4));
        load_all = (fields.kind == RT_LONG) && !timeout;
        load_low = is_short && !timeout;

        chk_word = bytes_in[127:96];
        chk_mask = '0;
        if (load_low) begin
            if (fields.idx == IDX_RCA) begin
                chk_word = {16'h0000, bytes_in[111:96]};
                chk_mask = {16'h0000, RCA_ERRMASK};
            end else if (fields.idx == IDX_OCR) begin
                chk_mask = '0;
            end else if ((fields.idx == IDX_IFCOND) && !card_is_mmc) begin
                chk_mask = '0;
            end else begin
                chk_mask = STATUS_ERRMASK;
            end
        end
        status_hit = |(chk_word & chk_mask & err_en);
    end
endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue
    import sdc_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_wr,
    input  logic [31:0]  cmd_wdata,
    input  logic [31:0]  arg_in,
    input  logic [31:0]  err_en,
    input  logic         init_mode,
    input  logic         card_present,
    input  logic         card_is_mmc,
    input  logic         xfer_done,
    output logic         req_valid,
    output logic [5:0]   req_index,
    output logic [31:0]  req_arg,
    input  logic         rsp_valid,
    input  logic [4:0]   rsp_len,
    input  logic [127:0] rsp_bytes,
    output logic [31:0]  cmd_reg,
    output logic [31:0]  resp_w0,
    output logic [31:0]  resp_w1,
    output logic [31:0]  resp_w2,
    output logic [31:0]  resp_w3,
    output logic [9:0]   pstate,
    output logic         xfer_dir,
    output logic         buf_reset,
    output logic         buf_rdy_clr,
    output logic         dma_drop,
    output logic         ev_cc,
    output logic         ev_cto,
    output logic         ev_cerr,
    output logic         ev_tc,
    output logic         stop_held
);
    localparam int PS_INHIBIT = 0;
    localparam int PS_DAT_LO  = 1;
    localparam int PS_DAT_HI  = 2;
    localparam int PS_WR      = 8;
    localparam int PS_RD      = 9;

    issue_st_e   state, state_nx;
    flow_e       flow_q, issue_flow;
    logic [31:0] arg_q, stop_word, stop_arg;
    logic [4:0]  lat_len;
    logic [127:0] lat_bytes;
    logic [RSP_WORDS-1:0][31:0] resp_q, eval_words;

    logic [31:0] wr_word, issue_word, issue_arg;
    cmd_fields_t wr_f, iss_f, cur_f;
    logic        wr_stop, iss_stop_unused, cur_stop;
    logic        stop_launch, defer, issue_go;
    logic        tmr_hit;
    logic        ev_timeout, ev_load_all, ev_load_low, ev_status_hit;

    assign wr_word = cmd_wdata & CMD_WMASK;

    sdc_cmd_decode u_dec_wr  (.word(wr_word),    .fields(wr_f),  .is_stop(wr_stop));
    sdc_cmd_decode u_dec_iss (.word(issue_word), .fields(iss_f), .is_stop(iss_stop_unused));
    sdc_cmd_decode u_dec_cur (.word(cmd_reg),    .fields(cur_f), .is_stop(cur_stop));

    sdc_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT), .hit(tmr_hit)
    );

    sdc_rsp_eval u_eval (
        .fields(cur_f), .card_is_mmc(card_is_mmc), .len(lat_len),
        .bytes_in(lat_bytes), .err_en(err_en), .timeout(ev_timeout),
        .load_all(ev_load_all), .load_low(ev_load_low),
        .status_hit(ev_status_hit), .words(eval_words)
    );

    // issue arbitration: a parked stop wins over a fresh write
    always_comb begin
        stop_launch = (state == ST_IDLE) && stop_held && !pstate[PS_DAT_HI];
        defer       = (state == ST_IDLE) && !stop_launch && cmd_wr &&
                      pstate[PS_DAT_HI] && !stop_held && wr_stop;
        issue_go    = stop_launch || ((state == ST_IDLE) && cmd_wr && !defer);
        issue_word  = stop_launch ? stop_word : wr_word;
        issue_arg   = stop_launch ? stop_arg  : arg_in;
        if (!card_present)
            issue_flow = FL_NOCARD;
        else if (init_mode && (iss_f.idx == 6'd0))
            issue_flow = FL_INIT0;
        else
            issue_flow = FL_NORMAL;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (issue_go) state_nx = (issue_flow == FL_NORMAL) ? ST_WAIT : ST_EVAL;
            ST_WAIT: if (rsp_valid || tmr_hit) state_nx = ST_EVAL;
            ST_EVAL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_q      <= FL_NORMAL;
            cmd_reg     <= '0;
            arg_q       <= '0;
            stop_word   <= '0;
            stop_arg    <= '0;
            stop_held   <= 1'b0;
            lat_len     <= '0;
            lat_bytes   <= '0;
            resp_q      <= '0;
            pstate      <= '0;
            xfer_dir    <= 1'b0;
            buf_reset   <= 1'b0;
            buf_rdy_clr <= 1'b0;
            dma_drop    <= 1'b0;
            ev_cc       <= 1'b0;
            ev_cto      <= 1'b0;
            ev_cerr     <= 1'b0;
            ev_tc       <= 1'b0;
        end else begin
            buf_reset   <= 1'b0;
            buf_rdy_clr <= 1'b0;
            dma_drop    <= 1'b0;
            ev_cc       <= 1'b0;
            ev_cto      <= 1'b0;
            ev_cerr     <= 1'b0;
            ev_tc       <= 1'b0;

            if (xfer_done) begin
                pstate[PS_DAT_HI:PS_DAT_LO] <= 2'b00;
                pstate[PS_RD:PS_WR]         <= 2'b00;
            end

            if (defer) begin
                stop_word <= wr_word;
                stop_arg  <= arg_in;
                stop_held <= 1'b1;
            end

            if (issue_go) begin
                cmd_reg            <= issue_word;
                arg_q              <= issue_arg;
                flow_q             <= issue_flow;
                lat_len            <= '0;
                pstate[PS_INHIBIT] <= 1'b1;
                if (stop_launch) stop_held <= 1'b0;
                if (issue_flow == FL_NORMAL) begin
                    if (iss_f.data_present) begin
                        pstate[PS_DAT_HI:PS_DAT_LO] <= 2'b11;
                        pstate[PS_RD]               <= iss_f.rd;
                        pstate[PS_WR]               <= !iss_f.rd;
                        xfer_dir                    <= iss_f.rd;
                        buf_reset                   <= 1'b1;
                    end else begin
                        pstate[PS_DAT_HI:PS_DAT_LO] <= 2'b00;
                        pstate[PS_RD:PS_WR]         <= 2'b00;
                    end
                end
            end

            if ((state == ST_WAIT) && rsp_valid) begin
                lat_len   <= rsp_len;
                lat_bytes <= rsp_bytes;
            end

            if (state == ST_EVAL) begin
                pstate[PS_INHIBIT] <= 1'b0;
                unique case (flow_q)
                    FL_INIT0:  ev_cc  <= 1'b1;
                    FL_NOCARD: ev_cto <= 1'b1;
                    default: begin
                        if (ev_load_all) resp_q <= eval_words;
                        if (ev_load_low) resp_q[0] <= eval_words[RSP_WORDS-1];
                        ev_cc  <= !ev_timeout;
                        ev_cto <= ev_timeout;
                        if (cur_stop || ev_status_hit) begin
                            pstate[PS_DAT_HI:PS_DAT_LO] <= 2'b00;
                            pstate[PS_RD:PS_WR]         <= 2'b00;
                        end
                        if (cur_stop) begin
                            buf_rdy_clr <= 1'b1;
                            dma_drop    <= 1'b1;
                        end
                        ev_cerr <= ev_status_hit;
                        ev_tc   <= cur_stop ||
                                   (!ev_status_hit && !ev_timeout &&
                                    !cur_f.data_present && (cur_f.kind == RT_BUSY));
                    end
                endcase
            end
        end
    end

    assign req_valid = (state == ST_WAIT);
    assign req_index = cur_f.idx;
    assign req_arg   = arg_q;
    assign resp_w0   = resp_q[0];
    assign resp_w1   = resp_q[1];
    assign resp_w2   = resp_q[2];
    assign resp_w3   = resp_q[3];
endmodule

// File: rtl/sdc_cmd_checker.sv
module sdc_cmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic [5:0]  req_index,
    input logic [31:0] req_arg,
    input logic [9:0]  pstate,
    input logic        buf_reset,
    input logic        buf_rdy_clr,
    input logic        dma_drop,
    input logic        ev_cc,
    input logic        ev_cto,
    input logic        ev_cerr,
    input logic        ev_tc,
    input logic        stop_held
);
    p_req_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> pstate[0]);

    p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |-> ($stable(req_index) && $stable(req_arg)));

    p_cc_cto_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_cc && ev_cto));

    p_cerr_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cerr |-> (pstate[2:1] == 2'b00));

    p_bufreset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        buf_reset |-> (pstate[2:1] == 2'b11));

    p_stop_pulses_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dma_drop |-> (ev_tc && buf_rdy_clr && !pstate[2]));

    p_hold_active_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_held) |-> $past(pstate[2]));
endmodule

bind sdc_cmd_issue sdc_cmd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .req_index(req_index), .req_arg(req_arg), .pstate(pstate),
    .buf_reset(buf_reset), .buf_rdy_clr(buf_rdy_clr), .dma_drop(dma_drop),
    .ev_cc(ev_cc), .ev_cto(ev_cto), .ev_cerr(ev_cerr), .ev_tc(ev_tc),
    .stop_held(stop_held)
);

// File: tb/sim_sdc_cmd_issue.sv
module sim_sdc_cmd_issue;
    localparam int TMO = 6;

    logic clk = 0, rst_n = 0;
    logic cmd_wr = 0, init_mode = 0, card_present = 1, card_is_mmc = 0, xfer_done = 0;
    logic [31:0] cmd_wdata = 0, arg_in = 0, err_en = 0;
    logic rsp_valid = 0;
    logic [4:0] rsp_len = 0;
    logic [127:0] rsp_bytes = 0;
    logic req_valid;
    logic [5:0] req_index;
    logic [31:0] req_arg, cmd_reg, resp_w0, resp_w1, resp_w2, resp_w3;
    logic [9:0] pstate;
    logic xfer_dir, buf_reset, buf_rdy_clr, dma_drop, ev_cc, ev_cto, ev_cerr, ev_tc, stop_held;

    sdc_cmd_issue #(.TIMEOUT_CYCLES(TMO)) u0 (.*);

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    int n_cc = 0, n_cto = 0, n_cerr = 0, n_tc = 0, n_br = 0, n_rc = 0, n_dd = 0;
    int b_cc, b_cto, b_cerr, b_tc, b_br, b_rc, b_dd;
    logic req_seen;
    logic [5:0] req_idx_seen;
    logic [31:0] req_arg_seen;
    logic [127:0] model_w = '0;

    always @(negedge clk) begin
        n_cc += int'(ev_cc); n_cto += int'(ev_cto); n_cerr += int'(ev_cerr);
        n_tc += int'(ev_tc); n_br += int'(buf_reset); n_rc += int'(buf_rdy_clr);
        n_dd += int'(dma_drop);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int idx, input int kind, input bit dp, input bit rd);
        return {2'b00, 6'(idx), 2'b00, dp, 3'b000, 2'(kind), 11'd0, rd, 4'd0};
    endfunction

    task automatic snap();
        b_cc = n_cc; b_cto = n_cto; b_cerr = n_cerr; b_tc = n_tc;
        b_br = n_br; b_rc = n_rc; b_dd = n_dd;
    endtask

    task automatic run_cmd(input logic [31:0] w, input logic [31:0] a, input bit respond,
                           input int len, input logic [127:0] bytes);
        snap();
        @(negedge clk); cmd_wdata = w; arg_in = a; cmd_wr = 1;
        @(negedge clk); cmd_wr = 0;
        req_seen = req_valid; req_idx_seen = req_index; req_arg_seen = req_arg;
        if (respond && req_valid) begin
            rsp_valid = 1; rsp_len = 5'(len); rsp_bytes = bytes;
            @(negedge clk); rsp_valid = 0;
        end
        repeat (TMO + 4) @(negedge clk);
    endtask

    task automatic end_xfer();
        @(negedge clk); xfer_done = 1;
        @(negedge clk); xfer_done = 0;
    endtask

    initial begin
        int lens[5] = '{0, 3, 4, 15, 16};
        int idxs[4] = '{3, 41, 8, 7};
        logic [31:0] pats[4] = '{32'h8000_0000, 32'h0000_0200, 32'h0000_0100, 32'h0000_0001};
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 events", {ev_cc, ev_cto, ev_cerr, ev_tc, buf_reset, buf_rdy_clr, dma_drop}, 0);
        check("R1 req/pstate", {req_valid, stop_held, pstate}, 0);
        check("R1 resp words", {resp_w3, resp_w2, resp_w1, resp_w0}, 0);
        rst_n = 1;
        @(negedge clk);

        // R4 R5 R6 R10 R11 sweep: type x length x data phase
        for (int k = 0; k < 4; k++)
            for (int li = 0; li < 5; li++)
                for (int dp = 0; dp < 2; dp++) begin
                    logic [127:0] by;
                    bit to, rd;
                    for (int b = 0; b < 16; b++) by[127-8*b -: 8] = 8'(b * 17 + k * 5 + li * 3 + dp);
                    rd = li[0];
                    to = (k == 1 && lens[li] < 16) || (k >= 2 && lens[li] < 4);
                    run_cmd(mk(17, k, dp[0], rd), 32'h1000 + 32'(li), 1, lens[li], by);
                    if (!to && k == 1) model_w = by;
                    if (!to && k >= 2) model_w[31:0] = by[127:96];
                    check("R3 request seen", {req_seen, req_idx_seen, req_arg_seen}, {1'b1, 6'd17, 32'h1000 + 32'(li)});
                    check("R5 cc", n_cc - b_cc, !to);
                    check("R6 cto", n_cto - b_cto, to);
                    check("R4 R5 words", {resp_w3, resp_w2, resp_w1, resp_w0}, model_w);
                    check("R10 tc", n_tc - b_tc, (!to && dp == 0 && k == 3));
                    check("R11 buf_reset", n_br - b_br, dp);
                    check("R11 pstate", {pstate[9:8], pstate[2:0]},
                          dp ? {rd, !rd, 3'b110} : 5'b0);
                    if (dp == 1) begin
                        check("R11 dir", xfer_dir, rd);
                        end_xfer();
                        @(negedge clk);
                        check("R11 done clears", pstate, 0);
                    end
                end

        // R6 no answer at all
        run_cmd(mk(9, 2, 0, 0), 0, 0, 0, 0);
        check("R6 silent short cto", {n_cto - b_cto, n_cc - b_cc}, {32'd1, 32'd0});
        run_cmd(mk(9, 0, 0, 0), 0, 0, 0, 0);
        check("R6 silent none cc", {n_cto - b_cto, n_cc - b_cc}, {32'd0, 32'd1});

        // R7 status class sweep
        for (int ii = 0; ii < 4; ii++)
            for (int m = 0; m < 2; m++)
                for (int p = 0; p < 4; p++)
                    for (int e = 0; e < 2; e++) begin
                        logic [31:0] mask, en;
                        bit hit;
                        en = e ? 32'hFFFF_FFFF : 32'h0;
                        if (idxs[ii] == 3) mask = 32'h0E00;
                        else if (idxs[ii] == 41) mask = 0;
                        else if (idxs[ii] == 8 && m == 0) mask = 0;
                        else mask = 32'hFDF9_8000;
                        hit = |(pats[p] & mask & en);
                        card_is_mmc = m[0]; err_en = en;
                        run_cmd(mk(idxs[ii], 2, 1, 1), 0, 1, 4, {pats[p], 96'd0});
                        check("R7 cerr", n_cerr - b_cerr, hit);
                        check("R7 transfer cancel", pstate[2], !hit);
                        end_xfer();
                    end
        err_en = 0; card_is_mmc = 0;

        // R8 init mode index 0
        init_mode = 1;
        run_cmd(mk(0, 2, 1, 0), 0, 1, 4, 0);
        check("R8 no request", req_seen, 0);
        check("R8 only cc", {n_cc - b_cc, n_cto - b_cto, n_tc - b_tc, n_br - b_br}, {32'd1, 32'd0, 32'd0, 32'd0});
        check("R8 pstate", pstate, 0);
        init_mode = 0;

        // R9 + R2 no card, full-ones write
        card_present = 0;
        run_cmd(32'hFFFF_FFFF, 0, 1, 16, 0);
        check("R9 no request", req_seen, 0);
        check("R9 only cto", {n_cto - b_cto, n_cc - b_cc, n_tc - b_tc, n_br - b_br}, {32'd1, 32'd0, 32'd0, 32'd0});
        check("R2 write mask", cmd_reg, 32'h3FFB_0037);
        card_present = 1;

        // R2 write while inhibited is dropped
        snap();
        @(negedge clk); cmd_wdata = mk(20, 2, 0, 0); cmd_wr = 1;
        @(negedge clk); cmd_wdata = mk(21, 2, 0, 0);
        @(negedge clk); cmd_wr = 0;
        check("R2 busy write ignored", cmd_reg, mk(20, 2, 0, 0));
        rsp_valid = 1; rsp_len = 4; rsp_bytes = 0;
        @(negedge clk); rsp_valid = 0;
        repeat (4) @(negedge clk);
        check("R2 single completion", n_cc - b_cc, 1);

        // R12 stop while idle
        run_cmd(mk(52, 2, 0, 0), 0, 1, 4, 0);
        check("R12 stop pulses", {n_tc - b_tc, n_dd - b_dd, n_rc - b_rc}, {32'd1, 32'd1, 32'd1});

        // R13 deferred stop
        run_cmd(mk(18, 2, 1, 1), 0, 1, 4, 0);
        snap();
        @(negedge clk); cmd_wdata = mk(12, 3, 0, 0); arg_in = 32'hABCD; cmd_wr = 1;
        @(negedge clk); cmd_wr = 0; arg_in = 0;
        check("R13 held", {stop_held, req_valid, pstate[2]}, 3'b101);
        repeat (3) @(negedge clk);
        check("R13 still held", {stop_held, req_valid, n_tc - b_tc}, {1'b1, 1'b0, 32'd0});
        end_xfer();
        for (int w = 0; w < 4 && !req_valid; w++) @(negedge clk);
        check("R13 stop issued", {req_valid, req_index, req_arg}, {1'b1, 6'd12, 32'hABCD});
        rsp_valid = 1; rsp_len = 4; rsp_bytes = 0;
        @(negedge clk); rsp_valid = 0;
        repeat (4) @(negedge clk);
        check("R13 R12 stop done", {n_tc - b_tc, n_dd - b_dd, n_rc - b_rc}, {32'd1, 32'd1, 32'd1});
        check("R13 released", {stop_held, pstate}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule